// File: doc/BRIEF.md
# Byte-to-Bit-Stream Transposer

This block turns a block of byte-oriented data into eight parallel bit streams. A producer hands it eight 128-bit words, sixteen bytes each, over a valid/ready handshake. Once the eighth word is in, the unit fills stream k with bit k of every byte, walking the bytes in order.

The datapath works by gathering bits. In each cycle it takes one buffered word, shifts every byte left so that the chosen bit sits at the top of its byte, and collects the top bit of all sixteen bytes into a 16-bit group. That group is then written into its slot of the matching stream. The first group written to a stream also clears the rest of that stream. The remaining groups overwrite only their own sixteen positions.

A block needs 8 × 8 = 64 such steps. The input is stalled while they run. When the streams are complete, a single-cycle done pulse flags them. The streams then stay unchanged until the next block starts transposing.

Top module: `bitstream_transposer`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it, all eight streams read zero, `out_done` is low and `in_ready` is high.
- R2: While no block is being transposed, `in_ready` is high. A word is taken on each rising edge where `in_valid` and `in_ready` are both high. Idle cycles between words are allowed. The eighth word taken completes a block and starts transposition on the next cycle.
- R3: During transposition `in_ready` is low. Words offered on `in_valid` in that time are not taken and do not appear in any result.
- R4: Bytes are numbered from the top of a word: byte j is `in_data[127-8j -: 8]`. Bits are numbered from the top of a byte: bit k is byte bit 7-k. Stream k is `out_streams[128k +: 128]`, and position p of a stream is bit 127-p of its slice. Position 16i+j of stream k equals bit k of byte j of word i, where i is the order in which the words were taken.
- R5: `out_done` rises on the 64th rising edge after the edge that took the eighth word, and it is high for exactly one cycle. `in_ready` returns high in that same cycle.
- R6: Outside transposition steps the streams hold their value. In particular, the result of a block stays unchanged while the next block is being loaded.
- R7: The result of a block depends only on that block's words. No bit of an earlier block survives into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Unit can take a word |
| in_data | input | 128 | Input word, byte 0 in the top bits |
| out_streams | output | 1024 | Eight 128-bit streams, stream k at bits 128k+127..128k |
| out_done | output | 1 | One-cycle pulse when the streams hold a complete block |

## Verification
The assertions check on every cycle the handshake rules: no word is taken while busy, ready is high whenever the unit is idle, and a full buffer starts a run. They also check that done is a single-cycle pulse that follows the last step after exactly 64 busy cycles, and that the streams never move outside a step. What they cannot show is bit placement, meaning which byte's bit lands at which stream position. They also cannot show that words offered during a run are truly dropped, or that nothing from one block leaks into the next. The bench's directed scenarios show these by comparing every stream against a model built straight from the mapping rule. They use random, single-bit-column, all-ones and all-zeros blocks, and blocks loaded with gaps or with stalled offers.

// File: rtl/xp_pkg.sv
package xp_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [0:0] {
    SQ_LOAD = 1'b0,
    SQ_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/xp_input_buffer.sv
module xp_input_buffer #(
  parameter int WORD_W    = 128,
  parameter int NUM_WORDS = 8,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic              block_full
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic [WORD_W-1:0] slots [NUM_WORDS];
  logic [IDX_W-1:0]  wr_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
    end else if (wr_en) begin
      wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_ptr] <= wr_data;
  end

  assign rd_word    = slots[rd_idx];
  assign block_full = wr_en && (wr_ptr == LAST_IDX);
endmodule

// File: rtl/xp_sequencer.sv
module xp_sequencer
  import xp_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int BIT_W    = $clog2(BYTE_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             block_full,
  output logic             busy,
  output logic             step_fire,
  output logic             step_first,
  output logic             last_step,
  output logic [IDX_W-1:0] word_idx,
  output logic [BIT_W-1:0] bit_idx,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(NUM_WORDS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BYTE_BITS - 1);

  seq_state_t state;

  assign busy       = (state == SQ_RUN);
  assign step_fire  = busy;
  assign step_first = busy && (word_idx == '0);
  assign last_step  = busy && (word_idx == LAST_WORD) && (bit_idx == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_LOAD;
      word_idx <= '0;
      bit_idx  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_LOAD: begin
          word_idx <= '0;
          bit_idx  <= '0;
          if (block_full) state <= SQ_RUN;
        end
        SQ_RUN: begin
          if (word_idx == LAST_WORD) begin
            word_idx <= '0;
            bit_idx  <= bit_idx + 1'b1;
          end else begin
            word_idx <= word_idx + 1'b1;
          end
          if (last_step) begin
            state <= SQ_LOAD;
            done  <= 1'b1;
          end
        end
        default: state <= SQ_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/xp_gather_unit.sv
module xp_gather_unit
  import xp_pkg::*;
#(
  parameter int WORD_BYTES = 16,
  localparam int WORD_W    = WORD_BYTES * BYTE_BITS,
  localparam int BIT_W     = $clog2(BYTE_BITS)
) (
  input  logic [WORD_W-1:0]     word,
  input  logic [BIT_W-1:0]      bit_sel,
  output logic [WORD_BYTES-1:0] mask
);
  // Shift each byte left by sh so the chosen bit reaches the top of its byte.
  function automatic logic [WORD_W-1:0] align_bytes(input logic [WORD_W-1:0] w,
                                                    input logic [BIT_W-1:0] sh);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WORD_BYTES; b++) begin
      r[b*BYTE_BITS +: BYTE_BITS] = w[b*BYTE_BITS +: BYTE_BITS] << sh;
    end
    return r;
  endfunction

  // Collect the top bit of each byte; byte 0 (top of word) goes to mask top.
  function automatic logic [WORD_BYTES-1:0] gather_top(input logic [WORD_W-1:0] w);
    logic [WORD_BYTES-1:0] m;
    for (int b = 0; b < WORD_BYTES; b++) begin
      m[b] = w[b*BYTE_BITS + BYTE_BITS - 1];
    end
    return m;
  endfunction

  logic [WORD_W-1:0] aligned;

  assign aligned = align_bytes(word, bit_sel);
  assign mask    = gather_top(aligned);
endmodule

// File: rtl/xp_stream_bank.sv
module xp_stream_bank
  import xp_pkg::*;
#(
  parameter int NUM_WORDS  = 8,
  parameter int WORD_BYTES = 16,
  localparam int STREAM_W  = NUM_WORDS * WORD_BYTES,
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int BIT_W     = $clog2(BYTE_BITS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          wr_first,
  input  logic [BIT_W-1:0]              stream_sel,
  input  logic [IDX_W-1:0]              group_sel,
  input  logic [WORD_BYTES-1:0]         group,
  output logic [BYTE_BITS*STREAM_W-1:0] streams
);
  // Place a group at slot g (slot 0 at the top); a first write clears the rest.
  function automatic logic [STREAM_W-1:0] place_group(input logic [STREAM_W-1:0] old,
                                                      input logic [WORD_BYTES-1:0] grp,
                                                      input logic [IDX_W-1:0] g,
                                                      input logic fresh);
    logic [STREAM_W-1:0] r;
    r = fresh ? '0 : old;
    r[STREAM_W - 1 - WORD_BYTES*int'(g) -: WORD_BYTES] = grp;
    return r;
  endfunction

  for (genvar s = 0; s < BYTE_BITS; s++) begin : g_stream
    logic [STREAM_W-1:0] sreg;
    always_ff @(posedge clk) begin
      if (rst) begin
        sreg <= '0;
      end else if (wr_en && (stream_sel == BIT_W'(s))) begin
        sreg <= place_group(sreg, group, group_sel, wr_first);
      end
    end
    assign streams[s*STREAM_W +: STREAM_W] = sreg;
  end
endmodule

// File: rtl/bitstream_transposer.sv
module bitstream_transposer
  import xp_pkg::*;
#(
  parameter int NUM_WORDS  = 8,
  parameter int WORD_BYTES = 16,
  localparam int WORD_W    = WORD_BYTES * BYTE_BITS,
  localparam int STREAM_W  = NUM_WORDS * WORD_BYTES,
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int BIT_W     = $clog2(BYTE_BITS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [WORD_W-1:0]             in_data,
  output logic [BYTE_BITS*STREAM_W-1:0] out_streams,
  output logic                          out_done
);
  // Named internal events, visible to the bound checker.
  logic                  busy;
  logic                  load_fire;
  logic                  block_full;
  logic                  step_fire;
  logic                  step_first;
  logic                  last_step;
  logic [IDX_W-1:0]      word_idx;
  logic [BIT_W-1:0]      bit_idx;
  logic [WORD_W-1:0]     cur_word;
  logic [WORD_BYTES-1:0] cur_mask;

  assign in_ready  = !busy;
  assign load_fire = in_valid && in_ready;

  xp_input_buffer #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_buf (
    .clk(clk), .rst(rst), .wr_en(load_fire), .wr_data(in_data),
    .rd_idx(word_idx), .rd_word(cur_word), .block_full(block_full)
  );

  xp_sequencer #(.NUM_WORDS(NUM_WORDS)) u_seq (
    .clk(clk), .rst(rst), .block_full(block_full), .busy(busy),
    .step_fire(step_fire), .step_first(step_first), .last_step(last_step),
    .word_idx(word_idx), .bit_idx(bit_idx), .done(out_done)
  );

  xp_gather_unit #(.WORD_BYTES(WORD_BYTES)) u_gat (
    .word(cur_word), .bit_sel(bit_idx), .mask(cur_mask)
  );

  xp_stream_bank #(.NUM_WORDS(NUM_WORDS), .WORD_BYTES(WORD_BYTES)) u_bank (
    .clk(clk), .rst(rst), .wr_en(step_fire), .wr_first(step_first),
    .stream_sel(bit_idx), .group_sel(word_idx), .group(cur_mask),
    .streams(out_streams)
  );
endmodule

// File: rtl/xp_checker.sv
module xp_checker #(
  parameter int NUM_STEPS = 64,
  parameter int OUT_W     = 1024
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             busy,
  input logic             load_fire,
  input logic             block_full,
  input logic             step_fire,
  input logic             last_step,
  input logic             out_done,
  input logic [OUT_W-1:0] out_streams
);
  logic [15:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (out_streams == '0 && !out_done && in_ready)); // R1
  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> in_ready); // R2
  AST_FULL_STARTS_RUN: assert property (@(posedge clk) disable iff (rst)
    block_full |=> busy); // R2
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!in_ready && !load_fire)); // R3
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    last_step |=> out_done); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    out_done |=> !out_done); // R5
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    out_done |-> (run_cnt == 16'(NUM_STEPS))); // R5
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!rst && !step_fire) |=> $stable(out_streams)); // R6
endmodule

bind bitstream_transposer xp_checker #(
  .NUM_STEPS(NUM_WORDS * xp_pkg::BYTE_BITS),
  .OUT_W(xp_pkg::BYTE_BITS * STREAM_W)
) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .busy(busy),
  .load_fire(load_fire), .block_full(block_full), .step_fire(step_fire),
  .last_step(last_step), .out_done(out_done), .out_streams(out_streams)
);

// File: tb/sim_bitstream_transposer.sv
module sim_bitstream_transposer;
  localparam int NW = 8;
  localparam int NB = 16;
  localparam int WW = NB * 8;
  localparam int SW = NW * NB;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [WW-1:0]     in_data = '0;
  logic [8*SW-1:0]   out_streams;
  logic              out_done;

  int total = 0;
  int bad   = 0;
  logic [31:0]     seed = 32'h1234_5678;
  logic [WW-1:0]   blk [NW];
  logic [8*SW-1:0] expect_all;

  always #5 clk = ~clk;

  bitstream_transposer u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_streams(out_streams), .out_done(out_done)
  );

  task automatic check(input string req, input string what,
                       input logic [8*SW-1:0] act, input logic [8*SW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(inout logic [31:0] s);
    s = s * 32'd1103515245 + 32'd12345;
    return s;
  endfunction

  // Model: position 16i+j of stream k = byte-bit (7-k) of byte j of word i.
  function automatic logic [8*SW-1:0] model();
    logic [8*SW-1:0] r = '0;
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < NW; i++)
        for (int j = 0; j < NB; j++)
          r[k*SW + (SW-1) - (NB*i + j)] = blk[i][(WW-1) - 8*j - k];
    return r;
  endfunction

  task automatic fill_random();
    for (int i = 0; i < NW; i++)
      for (int q = 0; q < WW/32; q++)
        blk[i][q*32 +: 32] = next_rand(seed);
  endtask

  task automatic fill_const(input logic [7:0] b);
    for (int i = 0; i < NW; i++) blk[i] = {NB{b}};
  endtask

  task automatic push(input logic [WW-1:0] w, input int gap);
    for (int g = 0; g < gap; g++) @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
  endtask

  // Load blk, wait for done, check latency, ready, pulse width and streams.
  task automatic run_block(input string tag, input int gap, input bit stall);
    int n = 0;
    int rdy_bad = 0;
    for (int i = 0; i < NW; i++) push(blk[i], gap);
    expect_all = model();
    while (!out_done && n < 200) begin
      if (stall) begin
        in_valid = 1'b1;
        in_data  = {NB{8'hA5}};
      end
      @(negedge clk);
      n++;
      if (!out_done && in_ready) rdy_bad++;
    end
    in_valid = 1'b0;
    in_data  = '0;
    check("R5", {tag, " done latency"}, (8*SW)'(n), (8*SW)'(64));
    check("R5", {tag, " ready back with done"}, (8*SW)'(in_ready), (8*SW)'(1));
    check("R3", {tag, " ready low while busy"}, (8*SW)'(rdy_bad), '0);
    check("R4", {tag, " streams"}, out_streams, expect_all);
    @(negedge clk);
    check("R5", {tag, " done one cycle"}, (8*SW)'(out_done), '0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "streams zero in reset", out_streams, '0);
    check("R1", "done low in reset", (8*SW)'(out_done), '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "streams zero after reset", out_streams, '0);
    check("R2", "ready high when idle", (8*SW)'(in_ready), (8*SW)'(1));
  endtask

  task automatic t_random();
    fill_random();
    run_block("R4 random", 0, 1'b0);
  endtask

  task automatic t_one_column();
    fill_const(8'h20);  // byte bit 5 = bit k=2 set in every byte
    run_block("R4 column", 0, 1'b0);
    check("R4", "stream 2 all ones", {{8*SW-SW{1'b0}}, out_streams[2*SW +: SW]},
          {{8*SW-SW{1'b0}}, {SW{1'b1}}});
  endtask

  task automatic t_gaps();
    fill_random();
    run_block("R2 gaps", 3, 1'b0);
  endtask

  task automatic t_stall();
    fill_random();
    run_block("R3 stall", 0, 1'b1);
    fill_random();
    run_block("R3 after stall", 1, 1'b0);
  endtask

  task automatic t_hold();
    logic [8*SW-1:0] prev;
    fill_random();
    run_block("R6 first", 0, 1'b0);
    prev = out_streams;
    fill_random();
    for (int i = 0; i < NW - 1; i++) push(blk[i], 1);
    repeat (5) @(negedge clk);
    check("R6", "held while loading next", out_streams, prev);
    begin
      int n = 0;
      push(blk[NW-1], 0);
      while (!out_done && n < 200) begin @(negedge clk); n++; end
      check("R6", "next block result", out_streams, model());
    end
  endtask

  task automatic t_no_leak();
    fill_const(8'hFF);
    run_block("R7 ones", 0, 1'b0);
    fill_const(8'h00);
    run_block("R7 zeros", 0, 1'b0);
    check("R7", "no residue", out_streams, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_random();
    t_one_column();
    t_gaps();
    t_stall();
    t_hold();
    t_no_leak();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule